// File: doc/BRIEF.md
# Legacy Replacement Interrupt Router

This block sits between the comparators of an event-timer unit and a bank of wired interrupt lines. Each timer presents a request, a 5-bit destination field, a trigger-type bit and a message-delivery flag. The router turns these into activity on one of up to 32 lines. Several timers may share a line. Two external legacy sources also feed the bank: a periodic-tick interrupt and a real-time-clock interrupt.

A single legacy-replacement control takes over the two legacy destinations. While it is on, timer 0 owns line 0 and timer 1 owns line 8, whatever their route fields hold. The external sources are cut off, and the tick-source output enable is dropped. The cycle in which the mode turns on quiets both lines. The cycle in which it turns off restores line 8 to the level the RTC input had one cycle earlier. All lines are registered, so every input is seen at the lines one clock later.

Top module: `lrr_router`

## Requirements
- R1: While legacy mode is on (and was on in the previous cycle), a firing timer 0 drives line 0 and a firing timer 1 drives line 8, whatever their route fields hold.
- R2: Timers 2 and up always drive the line whose index is held in their own 5-bit route field (timer i uses bits [5i+4:5i] of the route bus). Timers 0 and 1 do the same while legacy mode is off.
- R3: While legacy mode is off, the external tick input is ORed onto line 0 and the external RTC input onto line 8. While legacy mode is on, both have no effect on any line.
- R4: In the cycle in which legacy mode turns on, lines 0 and 8 are low whatever their sources, and the tick-source output enable goes low.
- R5: In the cycle in which legacy mode turns off, line 0 is low, the tick-source output enable goes high, and line 8 equals the RTC input level captured one clock earlier.
- R6: A timer whose type bit is 1 (level) holds its line high for as long as its request is high.
- R7: A timer whose type bit is 0 (edge) gives a single-cycle pulse on its line when its request goes from 0 to 1, and nothing while the request stays high.
- R8: A timer whose message-delivery flag is 1 has no effect on any line.
- R9: Sources that land on the same line are ORed together.
- R10: Lines are registered: inputs sampled at a clock edge appear on the lines after that edge. During and after reset all lines are low and the output enable is high.
- R11: The captured RTC level follows the input every cycle, including while legacy mode is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_en | input | 1 | Legacy-replacement mode control |
| tmr_route | input | NUM_TMR*5 | Per-timer destination line index, timer i at bits [5i+4:5i] |
| tmr_req | input | NUM_TMR | Per-timer interrupt request |
| tmr_level | input | NUM_TMR | Per-timer type: 1 level, 0 edge |
| tmr_msg_en | input | NUM_TMR | Per-timer message delivery; 1 keeps the timer off the wires |
| ext_tick_irq | input | 1 | External periodic-tick interrupt |
| ext_rtc_irq | input | 1 | External real-time-clock interrupt |
| irq_line | output | NUM_LINES | Interrupt lines |
| tick_out_en | output | 1 | Output enable for the external tick source |

## Verification
The bench targets the two mode transitions. A router that forgot the entry cycle would let the tick input or a stale timer glitch line 0 or 8. One that restored the live RTC level, or a level captured before the mode went on, would put the wrong value on line 8 at exit. It holds edge-type requests high for several cycles, so a router that treated them as level would keep the line up. It overlaps timers on one line, so a last-writer-wins merge would drop a request. It also sets the message flag on timers with live requests, so a router that still drives wires for those timers would raise a line.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
   // Where the legacy control stands, seen over the last two samples
   typedef enum logic [1:0] {
      PH_OFF   = 2'b00,
      PH_ENTER = 2'b01,
      PH_EXIT  = 2'b10,
      PH_ON    = 2'b11
   } leg_phase_e;

   localparam int LRR_MAX_LINES  = 32;
   localparam int LRR_MAX_TIMERS = 32;
   localparam int LRR_NO_LEGACY  = -1;
endpackage

// File: rtl/lrr_legacy_ctl.sv
module lrr_legacy_ctl
   import lrr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       legacy_en,
   input  logic       ext_rtc_irq,
   output leg_phase_e phase,
   output logic       leg_prev,
   output logic       rtc_held,
   output logic       tick_out_en
);
   logic tick_en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         leg_prev  <= 1'b0;
         rtc_held  <= 1'b0;
         tick_en_q <= 1'b1;
      end else begin
         leg_prev  <= legacy_en;
         rtc_held  <= ext_rtc_irq;
         tick_en_q <= ~legacy_en;
      end
   end

   always_comb begin
      unique case ({leg_prev, legacy_en})
         2'b00:   phase = PH_OFF;
         2'b01:   phase = PH_ENTER;
         2'b10:   phase = PH_EXIT;
         default: phase = PH_ON;
      endcase
   end

   assign tick_out_en = tick_en_q;

   AST_ENTER_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && !leg_prev) |=> !tick_out_en); // R4
   AST_EXIT_RAISES_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!legacy_en && leg_prev) |=> tick_out_en); // R5
   AST_RTC_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_en |=> (rtc_held == $past(ext_rtc_irq))); // R11
endmodule

// File: rtl/lrr_timer_src.sv
module lrr_timer_src
   import lrr_pkg::*;
#(
   parameter int NUM_LINES   = 32,
   parameter int LEGACY_LINE = LRR_NO_LEGACY,
   localparam int ROUTE_W    = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 legacy_en,
   input  logic [ROUTE_W-1:0]   route,
   input  logic                 req,
   input  logic                 level,
   input  logic                 msg_en,
   output logic [NUM_LINES-1:0] hit
);
   logic               req_q;
   logic [ROUTE_W-1:0] sel_line;
   logic               fire;

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req;
   end

   generate
      if (LEGACY_LINE == LRR_NO_LEGACY) begin : g_plain
         assign sel_line = route;
      end else begin : g_legacy
         localparam logic [ROUTE_W-1:0] FIXED = ROUTE_W'(LEGACY_LINE);
         assign sel_line = legacy_en ? FIXED : route;
      end
   endgenerate

   // level type follows the request; edge type fires on 0->1 only
   assign fire = ~msg_en & (level ? req : (req & ~req_q));
   assign hit  = fire ? (NUM_LINES'(1) << sel_line) : '0;
endmodule

// File: rtl/lrr_line_merge.sv
module lrr_line_merge
   import lrr_pkg::*;
#(
   parameter int NUM_TMR   = 4,
   parameter int NUM_LINES = 32,
   parameter int LINE_A    = 0,
   parameter int LINE_B    = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_TMR-1:0][NUM_LINES-1:0] hits,
   input  leg_phase_e                        phase,
   input  logic                              ext_tick_irq,
   input  logic                              ext_rtc_irq,
   input  logic                              rtc_held,
   output logic [NUM_LINES-1:0]              irq_line
);
   logic [NUM_LINES-1:0] acc;
   logic [NUM_LINES-1:0] irq_q;

   always_comb begin
      acc = '0;
      for (int t = 0; t < NUM_TMR; t++) acc = acc | hits[t];
      unique case (phase)
         PH_OFF: begin
            acc[LINE_A] = acc[LINE_A] | ext_tick_irq;
            acc[LINE_B] = acc[LINE_B] | ext_rtc_irq;
         end
         PH_ENTER: begin
            acc[LINE_A] = 1'b0;
            acc[LINE_B] = 1'b0;
         end
         PH_EXIT: begin
            acc[LINE_A] = 1'b0;
            acc[LINE_B] = rtc_held;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= acc;
   end

   assign irq_line = irq_q;

   AST_ENTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ENTER) |=> (!irq_line[LINE_A] && !irq_line[LINE_B])); // R4
   AST_EXIT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXIT) |=> (!irq_line[LINE_A] && irq_line[LINE_B] == $past(rtc_held))); // R5
   AST_OFF_TICK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_OFF && ext_tick_irq) |=> irq_line[LINE_A]); // R3
endmodule

// File: rtl/lrr_router.sv
module lrr_router
   import lrr_pkg::*;
#(
   parameter int NUM_TMR   = 4,
   parameter int NUM_LINES = 32,
   parameter int LINE_A    = 0,
   parameter int LINE_B    = 8,
   localparam int ROUTE_W  = $clog2(NUM_LINES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       legacy_en,
   input  logic [NUM_TMR*ROUTE_W-1:0] tmr_route,
   input  logic [NUM_TMR-1:0]         tmr_req,
   input  logic [NUM_TMR-1:0]         tmr_level,
   input  logic [NUM_TMR-1:0]         tmr_msg_en,
   input  logic                       ext_tick_irq,
   input  logic                       ext_rtc_irq,
   output logic [NUM_LINES-1:0]       irq_line,
   output logic                       tick_out_en
);
   generate
      if (NUM_TMR < 2 || NUM_TMR > LRR_MAX_TIMERS) begin : g_bad_tmr
         $error("lrr_router: NUM_TMR must lie in 2..32");
      end
      if (NUM_LINES < 2 || NUM_LINES > LRR_MAX_LINES || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
         $error("lrr_router: NUM_LINES must be a power of two up to 32");
      end
      if (LINE_A >= NUM_LINES || LINE_B >= NUM_LINES || LINE_A == LINE_B) begin : g_bad_legacy
         $error("lrr_router: legacy lines must be distinct and inside the bank");
      end
   endgenerate

   leg_phase_e                        phase;
   logic                              leg_prev;
   logic                              rtc_held;
   logic [NUM_TMR-1:0][NUM_LINES-1:0] hits;

   lrr_legacy_ctl i_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .legacy_en   (legacy_en),
      .ext_rtc_irq (ext_rtc_irq),
      .phase       (phase),
      .leg_prev    (leg_prev),
      .rtc_held    (rtc_held),
      .tick_out_en (tick_out_en)
   );

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      localparam int LEG = (t == 0) ? LINE_A : (t == 1) ? LINE_B : LRR_NO_LEGACY;
      lrr_timer_src #(
         .NUM_LINES   (NUM_LINES),
         .LEGACY_LINE (LEG)
      ) i_src (
         .clk       (clk),
         .rst_n     (rst_n),
         .legacy_en (legacy_en),
         .route     (tmr_route[t*ROUTE_W +: ROUTE_W]),
         .req       (tmr_req[t]),
         .level     (tmr_level[t]),
         .msg_en    (tmr_msg_en[t]),
         .hit       (hits[t])
      );
   end

   lrr_line_merge #(
      .NUM_TMR   (NUM_TMR),
      .NUM_LINES (NUM_LINES),
      .LINE_A    (LINE_A),
      .LINE_B    (LINE_B)
   ) i_merge (
      .clk          (clk),
      .rst_n        (rst_n),
      .hits         (hits),
      .phase        (phase),
      .ext_tick_irq (ext_tick_irq),
      .ext_rtc_irq  (ext_rtc_irq),
      .rtc_held     (rtc_held),
      .irq_line     (irq_line)
   );

   AST_LEG_T0_OWNS_A: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && leg_prev && tmr_req[0] && tmr_level[0] && !tmr_msg_en[0]) |=> irq_line[LINE_A]); // R1
   AST_LEG_T1_OWNS_B: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_en && leg_prev && tmr_req[1] && tmr_level[1] && !tmr_msg_en[1]) |=> irq_line[LINE_B]); // R1
   AST_MSG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((&tmr_msg_en) && legacy_en && leg_prev) |=> (irq_line == '0)); // R8
endmodule

// File: tb/test_lrr_router.sv
`timescale 1ns/1ps
module test_lrr_router;
   localparam int NT = 4;
   localparam int NL = 32;
   localparam int RW = 5;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            legacy_en;
   logic [NT*RW-1:0] tmr_route;
   logic [NT-1:0]   tmr_req, tmr_level, tmr_msg_en;
   logic            ext_tick_irq, ext_rtc_irq;
   logic [NL-1:0]   irq_line;
   logic            tick_out_en;

   int n_chk = 0;
   int n_err = 0;

   // bench-side model state: what the previous clock edge sampled
   logic          m_leg;
   logic [NT-1:0] m_req;
   logic          m_rtc;

   always #2.5 clk = ~clk;

   lrr_router #(.NUM_TMR(NT), .NUM_LINES(NL)) i_lrr_router (
      .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en), .tmr_route(tmr_route),
      .tmr_req(tmr_req), .tmr_level(tmr_level), .tmr_msg_en(tmr_msg_en),
      .ext_tick_irq(ext_tick_irq), .ext_rtc_irq(ext_rtc_irq),
      .irq_line(irq_line), .tick_out_en(tick_out_en)
   );

   function automatic logic [NL-1:0] calc_exp();
      logic [NL-1:0] v;
      v = '0;
      for (int i = 0; i < NT; i++) begin
         logic [RW-1:0] ln;
         ln = tmr_route[i*RW +: RW];
         if (legacy_en && i == 0) ln = 5'd0;
         if (legacy_en && i == 1) ln = 5'd8;
         if (!tmr_msg_en[i] && (tmr_level[i] ? tmr_req[i] : (tmr_req[i] && !m_req[i])))
            v[ln] = 1'b1;
      end
      case ({m_leg, legacy_en})
         2'b00: begin v[0] = v[0] | ext_tick_irq; v[8] = v[8] | ext_rtc_irq; end
         2'b01: begin v[0] = 1'b0; v[8] = 1'b0; end
         2'b10: begin v[0] = 1'b0; v[8] = m_rtc; end
         default: ;
      endcase
      return v;
   endfunction

   task automatic check_irq(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s irq_line actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_en(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s tick_out_en actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // called at a falling edge with inputs already set
   task automatic cyc(input string tag);
      logic [NL-1:0] e_irq;
      logic          e_en;
      e_irq = calc_exp();
      e_en  = ~legacy_en;
      m_leg = legacy_en;
      m_req = tmr_req;
      m_rtc = ext_rtc_irq;
      @(posedge clk);
      @(negedge clk);
      check_irq(tag, irq_line, e_irq);
      check_en(tag, tick_out_en, e_en);
   endtask

   task automatic set_route(input int t, input int ln);
      tmr_route[t*RW +: RW] = RW'(ln);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; legacy_en = 1'b0; tmr_route = '0; tmr_req = '0;
      tmr_level = '0; tmr_msg_en = '0; ext_tick_irq = 1'b1; ext_rtc_irq = 1'b1;
      m_leg = 1'b0; m_req = '0; m_rtc = 1'b0;
      repeat (3) @(negedge clk);
      check_irq("R10 reset", irq_line, '0);
      check_en("R10 reset", tick_out_en, 1'b1);
      ext_tick_irq = 1'b0; ext_rtc_irq = 1'b0;
      rst_n = 1'b1;

      // R6: level timer holds its line
      set_route(2, 5); tmr_level[2] = 1'b1; tmr_req[2] = 1'b1;
      repeat (3) cyc("R6");
      tmr_req[2] = 1'b0; cyc("R6");

      // R7: edge timer pulses once while request stays high
      set_route(3, 12); tmr_level[3] = 1'b0; tmr_req[3] = 1'b1;
      repeat (3) cyc("R7");
      tmr_req[3] = 1'b0; cyc("R7");

      // R2: timers 0/1 follow their route fields with legacy off
      set_route(0, 3); set_route(1, 4); tmr_level[1:0] = 2'b11; tmr_req[1:0] = 2'b11;
      cyc("R2");
      // R3: external sources pass with legacy off
      ext_tick_irq = 1'b1; ext_rtc_irq = 1'b1; cyc("R3");

      // R4: entering legacy mode quiets lines 0 and 8
      legacy_en = 1'b1; cyc("R4");
      // R1: timers 0/1 own lines 0/8; R3: externals blocked
      cyc("R1");
      tmr_req[1:0] = 2'b00; cyc("R3");
      // R11: RTC capture keeps following while legacy is on
      ext_rtc_irq = 1'b0; cyc("R11");
      ext_rtc_irq = 1'b1; cyc("R11");
      // R5: leaving restores captured RTC level (1) while input is 0
      legacy_en = 1'b0; ext_rtc_irq = 1'b0; cyc("R5");
      ext_tick_irq = 1'b0; cyc("R3");

      // R8: message-delivery timers stay off the wires
      tmr_msg_en = '1; tmr_level = '1; tmr_req = '1; cyc("R8");
      legacy_en = 1'b1; cyc("R8"); cyc("R8");
      legacy_en = 1'b0; cyc("R8");
      tmr_msg_en = '0; tmr_req = '0; cyc("R8");

      // R9: overlapping sources on one line
      for (int t = 0; t < NT; t++) set_route(t, 20);
      tmr_level = 4'b0101; tmr_req = 4'b0001; cyc("R9");
      tmr_req = 4'b0011; cyc("R9");
      tmr_req = 4'b0110; cyc("R9");
      tmr_req = 4'b0000; cyc("R9");

      // random mix
      for (int k = 0; k < 3000; k++) begin
         if (($urandom % 12) == 0) legacy_en = ~legacy_en;
         tmr_route    = NT*RW'($urandom);
         tmr_req      = NT'($urandom);
         tmr_level    = NT'($urandom);
         tmr_msg_en   = (($urandom % 4) == 0) ? NT'($urandom) : '0;
         ext_tick_irq = 1'($urandom);
         ext_rtc_irq  = 1'($urandom);
         cyc("R9 random");
      end
      finish_run();
   end
endmodule